// File: doc/BRIEF.md
# ISA Bus Target Front End

This block sits between a 16-bit ISA-style host bus and the register and memory side of a display controller. It watches the host address, the address-enable line, the high-byte enable and the four active-low strobes. When an I/O cycle or a memory cycle lands in one of its windows, it claims that cycle and turns it into a single request on a simple internal request/acknowledge port. The request carries the address, the byte enables and the write data.

While the internal side has not yet acknowledged, the block holds the channel-ready line low so that the host adds wait states. The block reports 16-bit capability for every decoded address. It drives the data bus only while a claimed read strobe is active. It does not claim I/O cycles while a DMA transfer is in progress. It does not claim memory cycles during a host DRAM refresh, and it ignores any memory address above the first megabyte. Byte-lane steering lets an 8-bit host reach the odd byte through the low data lane.

Top module: `isa_target_if`

## Requirements
- R1: While `aen` is 1, no I/O cycle is claimed. `iocs16_n` stays 1, `req` is not raised for the cycle, and neither `sd_oe` nor `iochrdy_oe` is driven.
- R2: A memory strobe is claimed only when address bits [21:20] are 0 and address bits [19:0] lie within [MEM_BASE, MEM_BASE+MEM_SPAN-1]. Any other address leaves `memcs16_n` at 1 and raises no request.
- R3: While `refresh_n` is 0, no memory cycle is claimed, and `memcs16_n` is 1.
- R4: `iocs16_n` is 0 in the same cycle in which `aen` is 0 and address bits [15:0] lie within [IO_BASE, IO_BASE+IO_SPAN-1]. `memcs16_n` is 0 in the same cycle in which the R2 window hits and `refresh_n` is 1. Both lines depend only on the address and these qualifiers, and not on the strobes.
- R5: The byte enables are `req_be[0] = ~A0` and `req_be[1] = ~sbhe_n | A0`. These give 2'b11 for an even word, 2'b01 for an even byte, and 2'b10 for an odd byte. `req_be` is never 0 while `req` is 1.
- R6: For an 8-bit odd access (A0 = 1 and `sbhe_n` = 1), the write data is taken from SD[7:0] and is presented on both lanes of `req_wdata`. For a read of this kind, the high byte of the read data is driven on both halves of `sd_out`. For every other access, the data passes straight through.
- R7: `iochrdy_oe` is 1 from the first clock edge after a claimed strobe is seen. It stays 1 up to, and including, the cycle in which `ack` is sampled, and it drops at that edge.
- R8: Each claimed strobe assertion produces exactly one request. `req` is raised at the first edge after the strobe. It stays 1 with a stable address and stable byte enables until `ack` is sampled. It does not rise again before the strobe is released.
- R9: `sd_oe` is 1 only while a claimed read strobe is still active, and `sd_out` carries the acknowledged read data once the wait has ended.
- R10: A strobe whose address misses both windows leaves every output inactive.
- R11: During and after reset, with no strobe active, `req`, `iochrdy_oe` and `sd_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 22 | Host address A[21:0] |
| aen | input | 1 | DMA cycle in progress when 1 |
| sbhe_n | input | 1 | High byte enable, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| smemr_n | input | 1 | First-megabyte memory read strobe, active low |
| smemw_n | input | 1 | First-megabyte memory write strobe, active low |
| refresh_n | input | 1 | Host DRAM refresh when 0 |
| sd_in | input | 16 | Data bus as seen at the pins |
| sd_out | output | 16 | Data bus value to drive |
| sd_oe | output | 1 | Data bus drive enable |
| iochrdy_oe | output | 1 | Pull channel-ready low when 1 |
| iocs16_n | output | 1 | 16-bit I/O capable, active low |
| memcs16_n | output | 1 | 16-bit memory capable, active low |
| req | output | 1 | Internal access request |
| req_write | output | 1 | Request is a write |
| req_is_io | output | 1 | Request is an I/O access |
| req_addr | output | 22 | Request address |
| req_be | output | 2 | Request byte enables |
| req_wdata | output | 16 | Request write data, lane-steered |
| ack | input | 1 | Internal access done |
| rdata | input | 16 | Internal read data, valid with ack |

## Verification
The cycles are tried with random addresses. Some are drawn inside each window, some next to a window and some in the second megabyte, so hits are separated from misses at every boundary. `aen` and `refresh_n` are also randomised against both cycle kinds, which shows that each qualifier blocks only its own space. All four combinations of A0 and `sbhe_n` appear with distinct data bytes on each lane, so a swapped or duplicated lane shows up in the checks. The acknowledge delay varies from zero to several cycles, which separates a wait that tracks `ack` from a wait of fixed length.

// File: rtl/isa_tgt_pkg.sv
package isa_tgt_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_WAIT = 2'd1,
    CYC_DONE = 2'd2
  } cyc_state_e;

  typedef struct packed {
    logic io;
    logic write;
  } cyc_kind_t;

endpackage

// File: rtl/isa_addr_decode.sv
module isa_addr_decode #(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned IO_DEC_W  = 16,
  parameter int unsigned MEM_DEC_W = 20,
  parameter int unsigned IO_BASE   = 'h3C0,
  parameter int unsigned IO_SPAN   = 32,
  parameter int unsigned MEM_BASE  = 'hA0000,
  parameter int unsigned MEM_SPAN  = 'h20000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              aen,
  input  logic              refresh_n,
  output logic              io_hit,
  output logic              mem_hit
);

  localparam logic [IO_DEC_W-1:0]  IO_LO  = IO_DEC_W'(IO_BASE);
  localparam logic [IO_DEC_W-1:0]  IO_HI  = IO_DEC_W'(IO_BASE + IO_SPAN - 1);
  localparam logic [MEM_DEC_W-1:0] MEM_LO = MEM_DEC_W'(MEM_BASE);
  localparam logic [MEM_DEC_W-1:0] MEM_HI = MEM_DEC_W'(MEM_BASE + MEM_SPAN - 1);
  localparam int unsigned          UP_W   = ADDR_W - MEM_DEC_W;

  logic [IO_DEC_W-1:0]  io_off;
  logic [MEM_DEC_W-1:0] mem_off;
  logic                 low_meg;
  logic                 io_in_range;
  logic                 mem_in_range;

  always_comb begin
    io_off       = addr[IO_DEC_W-1:0];
    mem_off      = addr[MEM_DEC_W-1:0];
    low_meg      = (addr[ADDR_W-1:MEM_DEC_W] == UP_W'(0));
    io_in_range  = (io_off >= IO_LO) && (io_off <= IO_HI);
    mem_in_range = (mem_off >= MEM_LO) && (mem_off <= MEM_HI);
    io_hit       = io_in_range && !aen;
    mem_hit      = mem_in_range && low_meg && refresh_n;
  end

endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              a0,
  input  logic              sbhe_n,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              swap_q,
  input  logic [DATA_W-1:0] int_rdata,
  output logic [1:0]        be,
  output logic              swap,
  output logic [DATA_W-1:0] int_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned HALF = DATA_W / 2;

  always_comb begin
    be[0] = !a0;
    be[1] = !sbhe_n || a0;
    swap  = a0 && sbhe_n;
    if (swap) begin
      int_wdata = {bus_wdata[HALF-1:0], bus_wdata[HALF-1:0]};
    end else begin
      int_wdata = bus_wdata;
    end
    if (swap_q) begin
      bus_rdata = {int_rdata[DATA_W-1:HALF], int_rdata[DATA_W-1:HALF]};
    end else begin
      bus_rdata = int_rdata;
    end
  end

endmodule

// File: rtl/isa_cycle_fsm.sv
module isa_cycle_fsm
  import isa_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       strobe_held,
  input  logic       ack,
  output cyc_state_e state
);

  cyc_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      CYC_IDLE: if (start) state_d = CYC_WAIT;
      CYC_WAIT: if (ack) state_d = strobe_held ? CYC_DONE : CYC_IDLE;
      CYC_DONE: if (!strobe_held) state_d = CYC_IDLE;
      default:  state_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CYC_IDLE;
    end else begin
      state <= state_d;
    end
  end

endmodule

// File: rtl/isa_target_if.sv
module isa_target_if
  import isa_tgt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IO_DEC_W  = 16,
  parameter int unsigned MEM_DEC_W = 20,
  parameter int unsigned IO_BASE   = 'h3C0,
  parameter int unsigned IO_SPAN   = 32,
  parameter int unsigned MEM_BASE  = 'hA0000,
  parameter int unsigned MEM_SPAN  = 'h20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              aen,
  input  logic              sbhe_n,
  input  logic              iord_n,
  input  logic              iowr_n,
  input  logic              smemr_n,
  input  logic              smemw_n,
  input  logic              refresh_n,
  input  logic [DATA_W-1:0] sd_in,
  output logic [DATA_W-1:0] sd_out,
  output logic              sd_oe,
  output logic              iochrdy_oe,
  output logic              iocs16_n,
  output logic              memcs16_n,
  output logic              req,
  output logic              req_write,
  output logic              req_is_io,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_be,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              ack,
  input  logic [DATA_W-1:0] rdata
);

  cyc_state_e        state;
  logic              io_hit;
  logic              mem_hit;
  logic              start;
  cyc_kind_t         kind_d;
  cyc_kind_t         kind_q;
  logic              strobe_held;
  logic              cap_en;
  logic              rd_en;
  logic [1:0]        be_d;
  logic              swap_d;
  logic              swap_q;
  logic [DATA_W-1:0] wdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] bus_rdata;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        be_q;
  logic [DATA_W-1:0] wdata_q;

  isa_addr_decode #(
    .ADDR_W   (ADDR_W),
    .IO_DEC_W (IO_DEC_W),
    .MEM_DEC_W(MEM_DEC_W),
    .IO_BASE  (IO_BASE),
    .IO_SPAN  (IO_SPAN),
    .MEM_BASE (MEM_BASE),
    .MEM_SPAN (MEM_SPAN)
  ) i_decode (
    .addr     (bus_addr),
    .aen      (aen),
    .refresh_n(refresh_n),
    .io_hit   (io_hit),
    .mem_hit  (mem_hit)
  );

  isa_lane_steer #(
    .DATA_W(DATA_W)
  ) i_lanes (
    .a0       (bus_addr[0]),
    .sbhe_n   (sbhe_n),
    .bus_wdata(sd_in),
    .swap_q   (swap_q),
    .int_rdata(rdata_q),
    .be       (be_d),
    .swap     (swap_d),
    .int_wdata(wdata_d),
    .bus_rdata(bus_rdata)
  );

  isa_cycle_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .strobe_held(strobe_held),
    .ack        (ack),
    .state      (state)
  );

  // Cycle recognition: I/O takes priority over memory if both were asserted.
  always_comb begin
    kind_d = '{io: 1'b0, write: 1'b0};
    start  = 1'b0;
    if (io_hit && (!iord_n || !iowr_n)) begin
      start  = 1'b1;
      kind_d = '{io: 1'b1, write: !iowr_n};
    end else if (mem_hit && (!smemr_n || !smemw_n)) begin
      start  = 1'b1;
      kind_d = '{io: 1'b0, write: !smemw_n};
    end
  end

  always_comb begin
    case ({kind_q.io, kind_q.write})
      2'b11:   strobe_held = !iowr_n;
      2'b10:   strobe_held = !iord_n;
      2'b01:   strobe_held = !smemw_n;
      default: strobe_held = !smemr_n;
    endcase
  end

  assign cap_en = (state == CYC_IDLE) && start;
  assign rd_en  = (state == CYC_WAIT) && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= '{io: 1'b0, write: 1'b0};
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      swap_q  <= 1'b0;
    end else if (cap_en) begin
      kind_q  <= kind_d;
      addr_q  <= bus_addr;
      be_q    <= be_d;
      wdata_q <= wdata_d;
      swap_q  <= swap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata;
    end
  end

  always_comb begin
    req        = (state == CYC_WAIT);
    iochrdy_oe = (state == CYC_WAIT);
    req_write  = kind_q.write;
    req_is_io  = kind_q.io;
    req_addr   = addr_q;
    req_be     = be_q;
    req_wdata  = wdata_q;
    sd_oe      = (state != CYC_IDLE) && !kind_q.write && strobe_held;
    sd_out     = bus_rdata;
    iocs16_n   = !io_hit;
    memcs16_n  = !mem_hit;
  end

endmodule

// File: rtl/isa_target_chk.sv
module isa_target_chk #(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned MEM_DEC_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              aen,
  input logic              refresh_n,
  input logic              iord_n,
  input logic              smemr_n,
  input logic              iocs16_n,
  input logic              memcs16_n,
  input logic              sd_oe,
  input logic              iochrdy_oe,
  input logic              req,
  input logic              req_is_io,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_be,
  input logic              ack
);

  AST_AEN_NO_IOCS: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> iocs16_n); // R1

  AST_IO_REQ_NOT_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req) && req_is_io) |-> !$past(aen)); // R1

  AST_MEM_FIRST_MEG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1:MEM_DEC_W] != '0) |-> memcs16_n); // R2

  AST_REFRESH_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_n |-> memcs16_n); // R3

  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (req_be != 2'b00)); // R5

  AST_WAIT_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    iochrdy_oe |-> req); // R7

  AST_WAIT_ENDS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> !iochrdy_oe); // R7

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(req_addr) && $stable(req_be))); // R8

  AST_SD_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> (!iord_n || !smemr_n)); // R9

endmodule

bind isa_target_if isa_target_chk #(
  .ADDR_W   (ADDR_W),
  .MEM_DEC_W(MEM_DEC_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .aen       (aen),
  .refresh_n (refresh_n),
  .iord_n    (iord_n),
  .smemr_n   (smemr_n),
  .iocs16_n  (iocs16_n),
  .memcs16_n (memcs16_n),
  .sd_oe     (sd_oe),
  .iochrdy_oe(iochrdy_oe),
  .req       (req),
  .req_is_io (req_is_io),
  .req_addr  (req_addr),
  .req_be    (req_be),
  .ack       (ack)
);

// File: tb/test_isa_target_if.sv
`timescale 1ns/1ps
module test_isa_target_if;

  localparam int unsigned IO_BASE  = 'h3C0;
  localparam int unsigned IO_SPAN  = 32;
  localparam int unsigned MEM_BASE = 'hA0000;
  localparam int unsigned MEM_SPAN = 'h20000;

  logic        clk;
  logic        rst_n;
  logic [21:0] bus_addr;
  logic        aen, sbhe_n, iord_n, iowr_n, smemr_n, smemw_n, refresh_n;
  logic [15:0] sd_in, sd_out, req_wdata, rdata;
  logic        sd_oe, iochrdy_oe, iocs16_n, memcs16_n;
  logic        req, req_write, req_is_io, ack;
  logic [21:0] req_addr;
  logic [1:0]  req_be;

  int checks = 0;
  int fails  = 0;

  isa_target_if i_isa_target_if (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .aen(aen), .sbhe_n(sbhe_n),
    .iord_n(iord_n), .iowr_n(iowr_n), .smemr_n(smemr_n), .smemw_n(smemw_n),
    .refresh_n(refresh_n), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
    .iochrdy_oe(iochrdy_oe), .iocs16_n(iocs16_n), .memcs16_n(memcs16_n),
    .req(req), .req_write(req_write), .req_is_io(req_is_io), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit f_io_hit(logic [21:0] a, logic dma);
    return !dma && (a[15:0] >= IO_BASE) && (a[15:0] <= IO_BASE + IO_SPAN - 1);
  endfunction

  function automatic bit f_mem_hit(logic [21:0] a, logic rf_n);
    return rf_n && (a[21:20] == 2'b00) &&
           (a[19:0] >= MEM_BASE) && (a[19:0] <= MEM_BASE + MEM_SPAN - 1);
  endfunction

  function automatic logic [1:0] f_be(logic a0, logic hi_n);
    return {!hi_n || a0, !a0};
  endfunction

  function automatic logic [15:0] f_wdata(logic a0, logic hi_n, logic [15:0] d);
    return (a0 && hi_n) ? {d[7:0], d[7:0]} : d;
  endfunction

  function automatic logic [15:0] f_rdata(logic a0, logic hi_n, logic [15:0] d);
    return (a0 && hi_n) ? {d[15:8], d[15:8]} : d;
  endfunction

  // kind: 0 I/O read, 1 I/O write, 2 memory read, 3 memory write
  task automatic run_cycle(int kind, logic [21:0] a, logic hi_n, logic dma,
                           logic rf_n, logic [15:0] wd, logic [15:0] rd, int dly);
    bit    is_io = (kind < 2);
    bit    is_wr = (kind == 1) || (kind == 3);
    bit    hit   = is_io ? f_io_hit(a, dma) : f_mem_hit(a, rf_n);
    string mtag;
    if (is_io && dma)                      mtag = "R1";
    else if (!is_io && (a[21:20] != 2'b00)) mtag = "R2";
    else if (!is_io && !rf_n)               mtag = "R3";
    else                                    mtag = "R10";
    @(negedge clk);
    bus_addr = a; sbhe_n = hi_n; aen = dma; refresh_n = rf_n; sd_in = wd; ack = 1'b0;
    case (kind)
      0: iord_n = 1'b0;
      1: iowr_n = 1'b0;
      2: smemr_n = 1'b0;
      default: smemw_n = 1'b0;
    endcase
    #1;
    chk("R4 iocs16_n", iocs16_n, !f_io_hit(a, dma));
    chk("R4 memcs16_n", memcs16_n, !f_mem_hit(a, rf_n));
    if (hit) begin
      @(negedge clk);
      chk("R8 req raised", req, 1'b1);
      chk("R7 wait asserted", iochrdy_oe, 1'b1);
      chk("R8 req_addr", req_addr, a);
      chk("R8 req_write", req_write, is_wr);
      chk("R8 req_is_io", req_is_io, is_io);
      chk("R5 req_be", req_be, f_be(a[0], hi_n));
      if (is_wr) chk("R6 req_wdata", req_wdata, f_wdata(a[0], hi_n, wd));
      else       chk("R9 sd_oe in read", sd_oe, 1'b1);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk("R7 wait held", iochrdy_oe, 1'b1);
        chk("R8 req held", req, 1'b1);
      end
      ack = 1'b1; rdata = rd;
      @(negedge clk);
      ack = 1'b0; rdata = 16'hDEAD;
      chk("R7 wait released", iochrdy_oe, 1'b0);
      chk("R8 req dropped", req, 1'b0);
      if (!is_wr) begin
        chk("R9 sd_oe held", sd_oe, 1'b1);
        chk("R6 sd_out", sd_out, f_rdata(a[0], hi_n, rd));
      end else begin
        chk("R9 no drive on write", sd_oe, 1'b0);
      end
      @(negedge clk);
      chk("R8 one request per strobe", req, 1'b0);
    end else begin
      repeat (2) begin
        @(negedge clk);
        chk({mtag, " miss req"}, req, 1'b0);
        chk({mtag, " miss wait"}, iochrdy_oe, 1'b0);
        chk({mtag, " miss sd_oe"}, sd_oe, 1'b0);
      end
    end
    iord_n = 1'b1; iowr_n = 1'b1; smemr_n = 1'b1; smemw_n = 1'b1;
    #1;
    chk("R9 sd_oe after strobe", sd_oe, 1'b0);
    @(negedge clk);
    chk("R8 idle after strobe", req, 1'b0);
  endtask

  initial begin
    logic [21:0] a;
    int          sel;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; bus_addr = '0; aen = 1'b0; sbhe_n = 1'b1;
    iord_n = 1'b1; iowr_n = 1'b1; smemr_n = 1'b1; smemw_n = 1'b1;
    refresh_n = 1'b1; sd_in = '0; ack = 1'b0; rdata = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset req", req, 1'b0);
    chk("R11 reset wait", iochrdy_oe, 1'b0);
    chk("R11 reset sd_oe", sd_oe, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 post-reset req", req, 1'b0);

    // directed corners
    run_cycle(0, 22'h0003C4, 1'b0, 1'b0, 1'b1, 16'h0, 16'hA55A, 0);    // word I/O read
    run_cycle(0, 22'h0003C5, 1'b1, 1'b0, 1'b1, 16'h0, 16'h7E81, 2);    // R6 odd byte, 8-bit host
    run_cycle(1, 22'h0003C5, 1'b1, 1'b0, 1'b1, 16'h12C3, 16'h0, 1);    // R6 odd byte write
    run_cycle(3, 22'h0A0001, 1'b0, 1'b0, 1'b1, 16'hBEEF, 16'h0, 3);    // odd byte on high lane
    run_cycle(1, 22'h0003C0, 1'b0, 1'b1, 1'b1, 16'h5555, 16'h0, 0);    // R1 DMA
    run_cycle(2, 22'h0A0010, 1'b0, 1'b0, 1'b0, 16'h0, 16'h1111, 0);    // R3 refresh
    run_cycle(2, 22'h1A0010, 1'b0, 1'b0, 1'b1, 16'h0, 16'h2222, 0);    // R2 second megabyte
    run_cycle(0, 22'h0003BF, 1'b0, 1'b0, 1'b1, 16'h0, 16'h3333, 0);    // R10 below window
    run_cycle(0, 22'h0003DF, 1'b0, 1'b0, 1'b1, 16'h0, 16'h4444, 0);    // top I/O entry
    run_cycle(1, 22'h0003E0, 1'b0, 1'b0, 1'b1, 16'h6666, 16'h0, 0);    // R10 above window
    run_cycle(2, 22'h0BFFFE, 1'b0, 1'b0, 1'b1, 16'h0, 16'h9876, 1);    // top memory word
    run_cycle(3, 22'h0C0000, 1'b0, 1'b0, 1'b1, 16'h7777, 16'h0, 0);    // R2 past window

    // constrained random
    for (int n = 0; n < 300; n++) begin
      int k = $urandom_range(0, 3);
      sel = $urandom_range(0, 3);
      case (sel)
        0: a = 22'(IO_BASE + $urandom_range(0, IO_SPAN - 1)) | 22'({$urandom_range(0, 63), 16'h0});
        1: a = 22'(MEM_BASE + $urandom_range(0, MEM_SPAN - 1));
        2: a = 22'(MEM_BASE + $urandom_range(0, MEM_SPAN - 1)) | 22'h100000;
        default: a = 22'($urandom);
      endcase
      run_cycle(k, a, 1'($urandom), ($urandom_range(0, 4) == 0),
                ($urandom_range(0, 4) != 0), 16'($urandom), 16'($urandom),
                $urandom_range(0, 4));
    end

    summary();
    $finish;
  end

endmodule